// File: doc/BRIEF.md
# Ripple-Slice ALU with Function-Field Decoder

This block is the arithmetic unit of a simple load-store processor datapath. A three-bit operation class from the main controller and the six-bit function field of register-register instructions enter a small decoder. The decoder produces a three-bit control word. Its top bit inverts the second operand. Its low two bits choose which per-bit value reaches the output: logical AND, logical OR, the adder sum, or the less-than input.

The datapath is a parameterized chain of one-bit slices joined by a ripple carry. The invert bit also serves as the carry into bit 0, so subtraction adds the two's complement of the second operand. The most significant slice is a separate variant. It derives signed overflow from the carries into and out of that bit, and it derives a corrected sign. That sign is fed back to the less-than input of bit 0, so set-on-less-than yields 1 or 0 in the low bit. A zero flag reports an all-zero result. The block has no storage: every output follows its inputs within the same cycle.

Top module: `alu_ripple_core`

## Requirements
- R1: Control word 3'b000 gives result = a AND b.
- R2: Control word 3'b001 gives result = a OR b.
- R3: Control word 3'b010 gives result = a + b, modulo 2^WIDTH.
- R4: Control word 3'b110 gives result = a - b, modulo 2^WIDTH.
- R5: Control word 3'b111 gives result = 1 when a is less than b as signed two's-complement numbers, and 0 otherwise. This holds even when a - b overflows. All bits above bit 0 are 0.
- R6: `zero` is 1 exactly when every result bit is 0.
- R7: `overflow` is 1 exactly when the adder operation (a + b when control bit 2 is 0, a - b when it is 1) leaves the signed WIDTH-bit range. This holds whatever the low control bits select.
- R8: The operation class values map to fixed control words, with no dependence on `func`: 3'b000 gives add, 3'b001 gives subtract, 3'b010 gives OR, 3'b011 gives AND, and 3'b101, 3'b110 and 3'b111 give AND.
- R9: For operation class 3'b100, the control word follows the function field f[5:0]. Bit 2 = !f2 & f1 & !f0. Bit 1 = !f2. Bit 0 = (!f3 & f2 & !f1 & f0) | (f3 & !f2 & f1 & !f0). So 6'h20 gives add, 6'h22 subtract, 6'h24 AND, 6'h25 OR and 6'h2A set-on-less-than, and f[5:4] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aluop | input | 3 | Operation class from the main controller |
| func | input | 6 | Function field of a register-register instruction |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected result |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the adder operation |

## Verification
The embedded checks assume the two operand buses and both decoder inputs are fully driven known values whenever they are sampled. They take the control word as given by the decoder alone, so they judge the slice chain only for the five control words the decoder can produce. The stimulus never leaves an input undriven. It sweeps all 512 class/function pairs at full width, and every operand pair for the five register-register functions on a four-bit copy, so every reachable control word meets both the overflow and non-overflow cases.

// File: rtl/alu_rc_pkg.sv
package alu_rc_pkg;
  localparam int ALUOP_W = 3;
  localparam int FUNC_W  = 6;
  localparam int CTRL_W  = 3;

  typedef logic [CTRL_W-1:0] alu_ctrl_t;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } slice_sel_e;

  localparam alu_ctrl_t CTRL_AND = 3'b000;
  localparam alu_ctrl_t CTRL_OR  = 3'b001;
  localparam alu_ctrl_t CTRL_ADD = 3'b010;
  localparam alu_ctrl_t CTRL_SUB = 3'b110;
  localparam alu_ctrl_t CTRL_SLT = 3'b111;
endpackage

// File: rtl/alu_rc_decoder.sv
module alu_rc_decoder
  import alu_rc_pkg::*;
(
  input  logic [ALUOP_W-1:0] aluop,
  input  logic [FUNC_W-1:0]  func,
  output alu_ctrl_t          ctrl
);
  logic rtype;

  always_comb begin
    rtype   = aluop[2] & ~aluop[1] & ~aluop[0];
    ctrl[2] = (~aluop[2] & ~aluop[1] & aluop[0])
            | (rtype & ~func[2] & func[1] & ~func[0]);
    ctrl[1] = (~aluop[2] & ~aluop[1])
            | (rtype & ~func[2]);
    ctrl[0] = (~aluop[2] & aluop[1] & ~aluop[0])
            | (rtype & ~func[3] & func[2] & ~func[1] & func[0])
            | (rtype & func[3] & ~func[2] & func[1] & ~func[0]);
  end

  // Fixed-class mapping checks (R8) and register-register codes (R9)
  always_comb begin
    if (aluop == 3'b000) p_class_add_r8: assert (ctrl == CTRL_ADD);
    if (aluop == 3'b001) p_class_sub_r8: assert (ctrl == CTRL_SUB);
    if (aluop == 3'b010) p_class_or_r8:  assert (ctrl == CTRL_OR);
    if (aluop[2] && (aluop[1:0] != 2'b00)) p_class_and_r8: assert (ctrl == CTRL_AND);
    if (aluop == 3'b100 && func[3:0] == 4'hA) p_func_slt_r9: assert (ctrl == CTRL_SLT);
    if (aluop == 3'b100 && func[3:0] == 4'h5) p_func_or_r9:  assert (ctrl == CTRL_OR);
  end
endmodule

// File: rtl/alu_rc_slice.sv
module alu_rc_slice
  import alu_rc_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       inv_b,
  input  logic       cin,
  input  logic       less,
  input  slice_sel_e sel,
  output logic       res,
  output logic       cout
);
  logic bx, sum;

  always_comb begin
    bx   = b ^ inv_b;
    sum  = a ^ bx ^ cin;
    cout = (a & bx) | (a & cin) | (bx & cin);
    unique case (sel)
      SEL_AND: res = a & bx;
      SEL_OR:  res = a | bx;
      SEL_SUM: res = sum;
      default: res = less;
    endcase
  end
endmodule

// File: rtl/alu_rc_msb_slice.sv
module alu_rc_msb_slice
  import alu_rc_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       inv_b,
  input  logic       cin,
  input  logic       less,
  input  slice_sel_e sel,
  output logic       res,
  output logic       set,
  output logic       ovf
);
  logic bx, sum, cout;

  always_comb begin
    bx   = b ^ inv_b;
    sum  = a ^ bx ^ cin;
    cout = (a & bx) | (a & cin) | (bx & cin);
    ovf  = cin ^ cout;
    set  = sum ^ ovf;
    unique case (sel)
      SEL_AND: res = a & bx;
      SEL_OR:  res = a | bx;
      SEL_SUM: res = sum;
      default: res = less;
    endcase
  end
endmodule

// File: rtl/alu_rc_chain.sv
module alu_rc_chain
  import alu_rc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] result,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic       inv_b;
  logic       set_w;
  slice_sel_e sel;

  assign inv_b = ctrl[2];
  assign sel   = slice_sel_e'(ctrl[1:0]);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic ci, lin, r;

    if (g == 0) begin : g_first
      assign ci  = inv_b;
      assign lin = set_w;
    end else begin : g_rest
      assign ci  = g_bit[g-1].g_low.co;
      assign lin = 1'b0;
    end

    if (g == MSB) begin : g_msb
      alu_rc_msb_slice u_slice (
        .a(a[g]), .b(b[g]), .inv_b(inv_b), .cin(ci), .less(lin),
        .sel(sel), .res(r), .set(set_w), .ovf(overflow)
      );
    end else begin : g_low
      logic co;
      alu_rc_slice u_slice (
        .a(a[g]), .b(b[g]), .inv_b(inv_b), .cin(ci), .less(lin),
        .sel(sel), .res(r), .cout(co)
      );
    end

    assign result[g] = r;
  end
endmodule

// File: rtl/alu_ripple_core.sv
module alu_ripple_core
  import alu_rc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [ALUOP_W-1:0] aluop,
  input  logic [FUNC_W-1:0]  func,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   result,
  output logic               zero,
  output logic               overflow
);
  alu_ctrl_t ctrl;

  alu_rc_decoder u_dec (
    .aluop(aluop), .func(func), .ctrl(ctrl)
  );

  alu_rc_chain #(.WIDTH(WIDTH)) u_chain (
    .a(a), .b(b), .ctrl(ctrl), .result(result), .overflow(overflow)
  );

  assign zero = ~|result;

  // Chain behaviour against the decoded control word
  always_comb begin
    if (ctrl == CTRL_AND) p_and_r1: assert (result == (a & b));
    if (ctrl == CTRL_OR)  p_or_r2:  assert (result == (a | b));
    if (ctrl == CTRL_ADD) p_add_r3: assert (result == WIDTH'(a + b));
    if (ctrl == CTRL_SUB) p_sub_r4: assert (result == WIDTH'(a - b));
    if (ctrl == CTRL_SLT)
      p_slt_r5: assert (result == {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))});
    if (ctrl == CTRL_SUB && a == b) p_eq_zero_r6: assert (zero);
    if (ctrl == CTRL_ADD)
      p_add_ovf_r7: assert (overflow == ((a[WIDTH-1] == b[WIDTH-1]) && (result[WIDTH-1] != a[WIDTH-1])));
  end
endmodule

// File: tb/test_alu_ripple_core.sv
module test_alu_ripple_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [2:0]  op32, op4;
  logic [5:0]  fn32, fn4;
  logic [31:0] a32, b32, r32;
  logic [3:0]  a4, b4, r4;
  logic        z32, v32, z4, v4;

  alu_ripple_core i_alu_ripple_core (
    .aluop(op32), .func(fn32), .a(a32), .b(b32),
    .result(r32), .zero(z32), .overflow(v32)
  );

  alu_ripple_core #(.WIDTH(4)) i_alu_ripple_core_w4 (
    .aluop(op4), .func(fn4), .a(a4), .b(b4),
    .result(r4), .zero(z4), .overflow(v4)
  );

  function automatic logic [2:0] exp_ctrl(logic [2:0] o, logic [5:0] f);
    logic [2:0] c;
    case (o)
      3'b000: c = 3'b010;
      3'b001: c = 3'b110;
      3'b010: c = 3'b001;
      3'b100: begin
        c[2] = !f[2] && f[1] && !f[0];
        c[1] = !f[2];
        c[0] = (!f[3] && f[2] && !f[1] && f[0]) || (f[3] && !f[2] && f[1] && !f[0]);
      end
      default: c = 3'b000;
    endcase
    return c;
  endfunction

  function automatic longint sx(longint v, int w);
    return v[w-1] ? v - (longint'(1) << w) : v;
  endfunction

  function automatic longint true_val(logic [2:0] c, longint x, longint y, int w);
    return c[2] ? sx(x, w) - sx(y, w) : sx(x, w) + sx(y, w);
  endfunction

  function automatic longint exp_res(logic [2:0] c, longint x, longint y, int w);
    longint mask = (longint'(1) << w) - 1;
    longint yy = c[2] ? (~y & mask) : y;
    longint tv = true_val(c, x, y, w);
    case (c[1:0])
      2'd0: return x & yy;
      2'd1: return (x | yy) & mask;
      2'd2: return tv & mask;
      default: return (tv < 0) ? 1 : 0;
    endcase
  endfunction

  function automatic bit exp_ovf(logic [2:0] c, longint x, longint y, int w);
    longint tv = true_val(c, x, y, w);
    return (tv > ((longint'(1) << (w-1)) - 1)) || (tv < -(longint'(1) << (w-1)));
  endfunction

  task automatic chk(string tag, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic run32(string tag, logic [2:0] o, logic [5:0] f, logic [31:0] x, logic [31:0] y);
    logic [2:0] c;
    longint er;
    @(posedge clk);
    op32 = o; fn32 = f; a32 = x; b32 = y;
    @(negedge clk);
    c  = exp_ctrl(o, f);
    er = exp_res(c, longint'(x), longint'(y), 32);
    chk(tag, "result", longint'(r32), er);
    chk("R6", "zero", longint'(z32), longint'(er == 0));
    chk("R7", "overflow", longint'(v32), longint'(exp_ovf(c, longint'(x), longint'(y), 32)));
  endtask

  task automatic run4(string tag, logic [5:0] f, logic [3:0] x, logic [3:0] y);
    logic [2:0] c;
    longint er;
    @(posedge clk);
    op4 = 3'b100; fn4 = f; a4 = x; b4 = y;
    @(negedge clk);
    c  = exp_ctrl(3'b100, f);
    er = exp_res(c, longint'(x), longint'(y), 4);
    chk(tag, "result4", longint'(r4), er);
    chk("R6", "zero4", longint'(z4), longint'(er == 0));
    chk("R7", "overflow4", longint'(v4), longint'(exp_ovf(c, longint'(x), longint'(y), 4)));
  endtask

  initial begin
    op32 = '0; fn32 = '0; a32 = '0; b32 = '0;
    op4 = '0; fn4 = '0; a4 = '0; b4 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle inputs: add of zeros
    chk("R3", "idle result", longint'(r32), 0);
    chk("R6", "idle zero", longint'(z32), 1);
    chk("R7", "idle overflow", longint'(v32), 0);

    // decoder sweep: R8 for fixed classes, R9 for register-register
    for (int o = 0; o < 8; o++) begin
      for (int f = 0; f < 64; f++) begin
        run32((o == 4) ? "R9" : "R8", 3'(o), 6'(f), 32'h8000_000C, 32'h0000_0005);
        run32((o == 4) ? "R9" : "R8", 3'(o), 6'(f), 32'h7FFF_FFFE, 32'hFFFF_FFFD);
      end
    end

    // exhaustive four-bit operands for each register-register function
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        run4("R1", 6'h24, 4'(x), 4'(y));
        run4("R2", 6'h25, 4'(x), 4'(y));
        run4("R3", 6'h20, 4'(x), 4'(y));
        run4("R4", 6'h22, 4'(x), 4'(y));
        run4("R5", 6'h2A, 4'(x), 4'(y));
      end
    end

    // full-width corners
    run32("R4", 3'b001, 6'h00, 32'h8000_0000, 32'h0000_0001);
    run32("R5", 3'b100, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF);
    run32("R5", 3'b100, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000);
    run32("R5", 3'b100, 6'h2A, 32'h1234_5678, 32'h1234_5678);
    run32("R3", 3'b000, 6'h3F, 32'h7FFF_FFFF, 32'h0000_0001);
    run32("R6", 3'b001, 6'h15, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    run32("R1", 3'b011, 6'h00, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    run32("R2", 3'b010, 6'h00, 32'hF0F0_0000, 32'h0000_0F0F);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule